// File: doc/BRIEF.md
# Cross-Domain Register Write Tracker

This block carries register writes from a fast bus clock domain into a slow low-power clock domain. It tracks each write and reports progress through a small status word. A bus write to any low-power register address is captured into a one-entry holding slot. The slot is handed to the slow domain with a toggle request, and the slow domain pulses a write port once the request has arrived. Two toggles return to the bus side. One reports that the slot contents have been taken, which frees the slot for the next write. The other reports that the write has been applied, which sets a write-complete flag.

The status word shows four flags. The busy flag is set while any write is in flight. The next flag is set while the holding slot is free. The complete flag clears itself when the status word is read. The error flag is sticky: it records a write that arrived while the slot was still occupied, and software clears it by writing a 1 to it. That clearing write travels through the slow domain like any other write. The interrupt-enable register sits entirely in the bus domain and takes effect on the next clock. Its three mask bits select which flags drive the interrupt output. The slow-domain registers are outside the block; the block only presents their write port.

Top module: `xdom_wr_tracker`

## Requirements
- R1: Each accepted write to an address other than the status and interrupt-enable addresses produces exactly one single-cycle pulse on the slow-domain write port, carrying the same address and data. Pulses come out in acceptance order.
- R2: Status bit 10 (busy) is 1 from the accepted write until the slow domain reports it applied. Status bit 9 (next) is 1 whenever the holding slot is free. Bit 9 returns to 1 once the slow domain has taken the slot, which happens while bit 10 is still 1.
- R3: Status bit 8 (write-complete) sets when the slow domain reports a write applied. This covers status-register writes as well.
- R4: A read at the status address returns the flags as they stood before the read, one cycle later on the read-data port. The read then clears bit 8. All other status bits read 0.
- R5: If a status read and a write completion fall in the same cycle, bit 8 stays set, and the following status read returns it as 1.
- R6: A write to the interrupt-enable address takes effect at once. It does not set bit 8, does not set bit 10, and produces no slow-domain pulse. Reading that address returns the stored mask in bits 9:7 and 0 elsewhere.
- R7: A write to a non-interrupt-enable address while bit 9 is 0 is dropped, producing no slow-domain pulse, and sets status bit 7 (write-error). Bit 7 stays set until cleared.
- R8: A write to the status address travels the slow-domain path without pulsing the write port. When it completes, it clears bit 7 if its data bit 7 is 1, and leaves bit 7 unchanged if its data bit 7 is 0.
- R9: The interrupt output is the OR of status bits 9, 8 and 7, each masked by the interrupt-enable bit at the same position.
- R10: After reset the status reads 0x200 (only bit 9 set), the interrupt-enable mask reads 0, and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| lp_clk | input | 1 | Slow low-power clock |
| lp_rst_n | input | 1 | Active-low reset, slow domain |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Masked OR of the next, complete and error flags |
| lp_wr_en | output | 1 | Slow-domain write pulse |
| lp_wr_addr | output | AW | Slow-domain write address |
| lp_wr_data | output | DW | Slow-domain write data |

## Verification
Suppose the in-flight count or the slot-taken state goes wrong. The status word then shows busy low with next low, or next stuck low, within one read after the slow-domain handshake. Any write that follows is dropped and raises the error flag in the very next cycle. A lost or duplicated toggle edge shows at the slow-domain write port as a missing, repeated or misordered pulse. It also shows as a complete flag that never sets, detected within a few slow-clock periods. A wrong read-clear priority shows at the ports when status is read on every cycle: the single read that should return the complete flag as 1 never occurs.

// File: rtl/xwt_pkg.sv
package xwt_pkg;
    localparam int STS_BUSY = 10;
    localparam int STS_NEXT = 9;
    localparam int STS_DONE = 8;
    localparam int STS_ERR  = 7;
    localparam int MASK_W   = STS_NEXT - STS_ERR + 1;
endpackage

// File: rtl/xwt_sync.sv
module xwt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/xwt_lp_side.sv
module xwt_lp_side #(
    parameter int             AW        = 4,
    parameter int             DW        = 32,
    parameter logic [AW-1:0]  STAT_ADDR = 5
) (
    input  logic          lp_clk,
    input  logic          lp_rst_n,
    input  logic          req_s,
    input  logic [AW-1:0] slot_addr,
    input  logic [DW-1:0] slot_data,
    output logic          take_tgl,
    output logic          done_tgl,
    output logic          lp_wr_en,
    output logic [AW-1:0] lp_wr_addr,
    output logic [DW-1:0] lp_wr_data
);
    typedef struct packed {
        logic          req_seen;
        logic          take_tgl;
        logic          done_tgl;
        logic          apply_pend;
        logic [AW-1:0] cap_addr;
        logic [DW-1:0] cap_data;
        logic          wr_en;
        logic [AW-1:0] out_addr;
        logic [DW-1:0] out_data;
    } lp_st_t;

    lp_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        // apply the captured write one slow cycle after capture
        if (st_q.apply_pend) begin
            st_d.apply_pend = 1'b0;
            st_d.done_tgl   = ~st_q.done_tgl;
            st_d.wr_en      = (st_q.cap_addr != STAT_ADDR);
            st_d.out_addr   = st_q.cap_addr;
            st_d.out_data   = st_q.cap_data;
        end
        // a new request edge: take the bus holding slot
        if (req_s != st_q.req_seen) begin
            st_d.req_seen   = req_s;
            st_d.cap_addr   = slot_addr;
            st_d.cap_data   = slot_data;
            st_d.take_tgl   = ~st_q.take_tgl;
            st_d.apply_pend = 1'b1;
        end
    end

    always_ff @(posedge lp_clk or negedge lp_rst_n) begin
        if (!lp_rst_n) st_q <= '0;
        else           st_q <= st_d;
    end

    assign take_tgl   = st_q.take_tgl;
    assign done_tgl   = st_q.done_tgl;
    assign lp_wr_en   = st_q.wr_en;
    assign lp_wr_addr = st_q.out_addr;
    assign lp_wr_data = st_q.out_data;
endmodule

// File: rtl/xwt_bus_side.sv
module xwt_bus_side
    import xwt_pkg::*;
#(
    parameter int             AW        = 4,
    parameter int             DW        = 32,
    parameter logic [AW-1:0]  STAT_ADDR = 5,
    parameter logic [AW-1:0]  IEN_ADDR  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              take_s,
    input  logic              done_s,
    output logic              req_tgl,
    output logic [AW-1:0]     slot_addr,
    output logic [DW-1:0]     slot_data,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic              busy,
    output logic              next,
    output logic              wc,
    output logic              we,
    output logic [MASK_W-1:0] ien,
    output logic              done_evt
);
    typedef struct packed {
        logic [AW-1:0]     slot_addr;
        logic [DW-1:0]     slot_data;
        logic              slot_clr;
        logic              slot_full;
        logic              fly_clr;
        logic              req_tgl;
        logic [1:0]        outst;
        logic              wc;
        logic              we;
        logic [MASK_W-1:0] ien;
        logic              take_seen;
        logic              done_seen;
        logic [DW-1:0]     rdata;
    } bus_st_t;

    bus_st_t st_d, st_q;

    logic take_evt;
    logic is_ien, is_stat, wr_ok, wr_bad, clr_now;
    logic [DW-1:0] sts_word, ien_word;

    always_comb begin
        take_evt = take_s ^ st_q.take_seen;
        done_evt = done_s ^ st_q.done_seen;
        is_ien   = (bus_addr == IEN_ADDR);
        is_stat  = (bus_addr == STAT_ADDR);
        wr_ok    = bus_wr && !is_ien && !st_q.slot_full;
        wr_bad   = bus_wr && !is_ien &&  st_q.slot_full;
        clr_now  = done_evt && st_q.fly_clr;

        sts_word           = '0;
        sts_word[STS_BUSY] = (st_q.outst != 2'd0);
        sts_word[STS_NEXT] = !st_q.slot_full;
        sts_word[STS_DONE] = st_q.wc;
        sts_word[STS_ERR]  = st_q.we;
        ien_word                  = '0;
        ien_word[STS_NEXT:STS_ERR] = st_q.ien;

        st_d           = st_q;
        st_d.take_seen = take_s;
        st_d.done_seen = done_s;
        st_d.outst     = st_q.outst + {1'b0, wr_ok} - {1'b0, done_evt};

        // slot handed over: its clear-error marker now rides with the in-flight write
        if (take_evt) begin
            st_d.slot_full = 1'b0;
            st_d.fly_clr   = st_q.slot_clr;
        end
        if (wr_ok) begin
            st_d.slot_addr = bus_addr;
            st_d.slot_data = bus_wdata;
            st_d.slot_clr  = is_stat && bus_wdata[STS_ERR];
            st_d.slot_full = 1'b1;
            st_d.req_tgl   = ~st_q.req_tgl;
        end
        if (bus_wr && is_ien) begin
            st_d.ien = bus_wdata[STS_NEXT:STS_ERR];
        end

        // error: a new drop wins over a clear in the same cycle
        if (clr_now) st_d.we = 1'b0;
        if (wr_bad)  st_d.we = 1'b1;

        // complete: a completion wins over a read-clear in the same cycle
        if (bus_rd && is_stat) st_d.wc = 1'b0;
        if (done_evt)          st_d.wc = 1'b1;

        if (bus_rd) begin
            if (is_stat)     st_d.rdata = sts_word;
            else if (is_ien) st_d.rdata = ien_word;
            else             st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tgl   = st_q.req_tgl;
    assign slot_addr = st_q.slot_addr;
    assign slot_data = st_q.slot_data;
    assign bus_rdata = st_q.rdata;
    assign busy      = (st_q.outst != 2'd0);
    assign next      = !st_q.slot_full;
    assign wc        = st_q.wc;
    assign we        = st_q.we;
    assign ien       = st_q.ien;
    assign irq       = |({!st_q.slot_full, st_q.wc, st_q.we} & st_q.ien);
endmodule

// File: rtl/xdom_wr_tracker.sv
module xdom_wr_tracker
    import xwt_pkg::*;
#(
    parameter int             AW          = 4,
    parameter int             DW          = 32,
    parameter logic [AW-1:0]  STAT_ADDR   = 5,
    parameter logic [AW-1:0]  IEN_ADDR    = 6,
    parameter int             SYNC_STAGES = 2
) (
    input  logic          bus_clk,
    input  logic          bus_rst_n,
    input  logic          lp_clk,
    input  logic          lp_rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          lp_wr_en,
    output logic [AW-1:0] lp_wr_addr,
    output logic [DW-1:0] lp_wr_data
);
    logic              req_tgl_w, req_s_w;
    logic              take_tgl_w, take_s_w;
    logic              done_tgl_w, done_s_w;
    logic [AW-1:0]     slot_addr_w;
    logic [DW-1:0]     slot_data_w;
    logic              busy_w, next_w, wc_w, we_w, done_evt_w;
    logic [MASK_W-1:0] ien_w;

    xwt_bus_side #(
        .AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)
    ) u_bus (
        .clk      (bus_clk),
        .rst_n    (bus_rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .take_s   (take_s_w),
        .done_s   (done_s_w),
        .req_tgl  (req_tgl_w),
        .slot_addr(slot_addr_w),
        .slot_data(slot_data_w),
        .bus_rdata(bus_rdata),
        .irq      (irq),
        .busy     (busy_w),
        .next     (next_w),
        .wc       (wc_w),
        .we       (we_w),
        .ien      (ien_w),
        .done_evt (done_evt_w)
    );

    xwt_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(lp_clk), .rst_n(lp_rst_n), .d(req_tgl_w), .q(req_s_w)
    );
    xwt_sync #(.STAGES(SYNC_STAGES)) u_sync_take (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(take_tgl_w), .q(take_s_w)
    );
    xwt_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(done_tgl_w), .q(done_s_w)
    );

    xwt_lp_side #(
        .AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR)
    ) u_lp (
        .lp_clk    (lp_clk),
        .lp_rst_n  (lp_rst_n),
        .req_s     (req_s_w),
        .slot_addr (slot_addr_w),
        .slot_data (slot_data_w),
        .take_tgl  (take_tgl_w),
        .done_tgl  (done_tgl_w),
        .lp_wr_en  (lp_wr_en),
        .lp_wr_addr(lp_wr_addr),
        .lp_wr_data(lp_wr_data)
    );
endmodule

// File: rtl/xdom_wr_tracker_chk.sv
module xdom_wr_tracker_chk #(
    parameter int             AW        = 4,
    parameter logic [AW-1:0]  STAT_ADDR = 5,
    parameter logic [AW-1:0]  IEN_ADDR  = 6
) (
    input logic          bus_clk,
    input logic          bus_rst_n,
    input logic          lp_clk,
    input logic          lp_rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic          busy,
    input logic          next,
    input logic          wc,
    input logic          we,
    input logic [2:0]    ien,
    input logic          irq,
    input logic          done_evt,
    input logic          lp_wr_en,
    input logic [AW-1:0] lp_wr_addr
);
    // R2
    idle_slot_free_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !busy |-> next);

    // R7
    drop_sets_err_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_wr && !next && bus_addr != IEN_ADDR) |=> we);

    // R4
    read_clears_done_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_rd && bus_addr == STAT_ADDR && !done_evt) |=> !wc);

    // R5
    done_wins_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        done_evt |=> wc);

    // R6
    ien_no_busy_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_wr && bus_addr == IEN_ADDR && !busy) |=> !busy);

    // R9
    irq_masked_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (ien == 3'b000) |-> !irq);

    // R8
    stat_no_port_chk: assert property (@(posedge lp_clk) disable iff (!lp_rst_n)
        lp_wr_en |-> (lp_wr_addr != STAT_ADDR));

    // R1
    single_pulse_chk: assert property (@(posedge lp_clk) disable iff (!lp_rst_n)
        lp_wr_en |=> !lp_wr_en);
endmodule

bind xdom_wr_tracker xdom_wr_tracker_chk #(
    .AW(AW), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)
) u_chk (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .lp_clk    (lp_clk),
    .lp_rst_n  (lp_rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .busy      (busy_w),
    .next      (next_w),
    .wc        (wc_w),
    .we        (we_w),
    .ien       (ien_w),
    .irq       (irq),
    .done_evt  (done_evt_w),
    .lp_wr_en  (lp_wr_en),
    .lp_wr_addr(lp_wr_addr)
);

// File: tb/xdom_wr_tracker_tb.sv
module xdom_wr_tracker_tb;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam logic [AW-1:0] STAT = 4'd5;
    localparam logic [AW-1:0] IENA = 4'd6;

    logic bus_clk = 1'b0, lp_clk = 1'b0;
    logic bus_rst_n = 1'b0, lp_rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic irq, lp_wr_en;
    logic [AW-1:0] lp_wr_addr;
    logic [DW-1:0] lp_wr_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    logic [AW-1:0] mon_addr [64];
    logic [DW-1:0] mon_data [64];
    int mon_n = 0;

    always #10 bus_clk = ~bus_clk;
    initial begin
        #13;
        forever #35 lp_clk = ~lp_clk;
    end

    xdom_wr_tracker #(.AW(AW), .DW(DW), .STAT_ADDR(STAT), .IEN_ADDR(IENA)) u_dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .lp_clk(lp_clk), .lp_rst_n(lp_rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .lp_wr_en(lp_wr_en),
        .lp_wr_addr(lp_wr_addr), .lp_wr_data(lp_wr_data)
    );

    always @(negedge lp_clk) begin
        if (lp_wr_en && mon_n < 64) begin
            mon_addr[mon_n] = lp_wr_addr;
            mon_data[mon_n] = lp_wr_data;
            mon_n = mon_n + 1;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge bus_clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
        end
    end

    task automatic bwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge bus_clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [AW-1:0] a, output logic [DW-1:0] r);
        @(negedge bus_clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge bus_clk);
        bus_rd = 1'b0;
        r = bus_rdata;
    endtask

    // poll status until busy (bit 10) is 0; return that read
    task automatic wait_idle(output logic [DW-1:0] s);
        s = '1;
        for (int i = 0; i < 400; i++) begin
            bread(STAT, s);
            if (!s[10]) return;
        end
        chk("R2 idle timeout", s, 32'h0);
    endtask

    function automatic logic [DW-1:0] sts(input bit b, input bit n, input bit c, input bit e);
        return (DW'(b) << 10) | (DW'(n) << 9) | (DW'(c) << 8) | (DW'(e) << 7);
    endfunction

    logic [DW-1:0] r, s;
    int base, ones, nb_seen;

    initial begin
        repeat (3) @(negedge bus_clk);
        bus_rst_n = 1'b1; lp_rst_n = 1'b1;
        repeat (2) @(negedge bus_clk);

        // R10 reset state
        chk("R10 irq after reset", DW'(irq), 32'h0);
        bread(STAT, r); chk("R10 status after reset", r, 32'h200);
        bread(IENA, r); chk("R10 mask after reset", r, 32'h0);

        // R1 R3 sweep over every plain address
        for (int a = 0; a < 16; a++) begin
            if (a == 5 || a == 6) continue;
            for (int k = 0; k < 2; k++) begin
                logic [DW-1:0] d;
                d = (32'h01010101 * a) ^ (k ? 32'hA5C3_0F96 : 32'h0000_0000);
                base = mon_n;
                bwrite(AW'(a), d);
                wait_idle(s);
                chk("R3 status after write", s, sts(0, 1, 1, 0));
                repeat (6) @(negedge bus_clk);
                chk("R1 pulse count", DW'(mon_n - base), 32'h1);
                chk("R1 pulse addr", DW'(mon_addr[base]), DW'(a));
                chk("R1 pulse data", mon_data[base], d);
            end
        end

        // R4 read clears complete
        bread(STAT, r); chk("R4 complete cleared by read", r, sts(0, 1, 0, 0));

        // R2 R5 read status on every cycle across one write
        bwrite(4'd3, 32'h1234_5678);
        ones = 0; nb_seen = 0;
        @(negedge bus_clk);
        bus_rd = 1'b1; bus_addr = STAT;
        for (int i = 0; i < 300; i++) begin
            @(negedge bus_clk);
            if (bus_rdata[8]) ones++;
            if (bus_rdata[10] && bus_rdata[9]) nb_seen++;
            if (!bus_rdata[10] && i > 2) break;
        end
        @(negedge bus_clk);
        if (bus_rdata[8]) ones++;
        bus_rd = 1'b0;
        chk("R5 complete seen once under continuous reads", DW'(ones), 32'h1);
        chk("R2 next rose while busy", DW'(nb_seen > 0), 32'h1);

        // R2 R1 pipelined second write staged after next returns
        base = mon_n;
        bwrite(4'd1, 32'hAAAA_0001);
        for (int i = 0; i < 300; i++) begin
            bread(STAT, r);
            if (r[9]) break;
        end
        bwrite(4'd2, 32'hBBBB_0002);
        wait_idle(s);
        chk("R2 no error on staged write", DW'(s[7]), 32'h0);
        repeat (6) @(negedge bus_clk);
        chk("R1 pipelined count", DW'(mon_n - base), 32'h2);
        chk("R1 order first", mon_data[base], 32'hAAAA_0001);
        chk("R1 order second", mon_data[base + 1], 32'hBBBB_0002);

        // R6 mask write is immediate and silent
        base = mon_n;
        bread(STAT, r);
        bwrite(IENA, 32'hFFFF_FFFF);
        bread(IENA, r); chk("R6 mask readback", r, 32'h380);
        bread(STAT, r); chk("R6 no complete, no busy", r, sts(0, 1, 0, 0));
        chk("R6 no slow pulse", DW'(mon_n - base), 32'h0);
        chk("R9 next enabled drives irq", DW'(irq), 32'h1);

        // R7 collision: back-to-back writes, second dropped
        bwrite(IENA, 32'h0000_0080);
        base = mon_n;
        @(negedge bus_clk);
        bus_wr = 1'b1; bus_addr = 4'd7; bus_wdata = 32'hC0DE_0007;
        @(negedge bus_clk);
        bus_addr = 4'd8; bus_wdata = 32'hDEAD_0008;
        @(negedge bus_clk);
        bus_wr = 1'b0;
        chk("R9 error raises irq", DW'(irq), 32'h1);
        wait_idle(s);
        chk("R7 error sticky after completion", s, sts(0, 1, 1, 1));
        repeat (6) @(negedge bus_clk);
        chk("R7 only first write reached port", DW'(mon_n - base), 32'h1);
        chk("R7 surviving data", mon_data[base], 32'hC0DE_0007);

        // R8 status write with bit 7 = 0 keeps error
        base = mon_n;
        bwrite(STAT, 32'h0000_0000);
        wait_idle(s);
        chk("R8 bit7=0 keeps error", s, sts(0, 1, 1, 1));
        // R8 status write with bit 7 = 1 clears error
        bwrite(STAT, 32'h0000_0080);
        wait_idle(s);
        chk("R8 bit7=1 clears error", s, sts(0, 1, 1, 0));
        repeat (6) @(negedge bus_clk);
        chk("R8 status writes give no pulse", DW'(mon_n - base), 32'h0);
        chk("R9 irq low after error cleared", DW'(irq), 32'h0);

        // R9 complete interrupt
        bwrite(IENA, 32'h0000_0100);
        bwrite(4'd9, 32'h0BAD_F00D);
        for (int i = 0; i < 300; i++) begin
            @(negedge bus_clk);
            if (irq) break;
        end
        chk("R9 complete raises irq", DW'(irq), 32'h1);
        bread(STAT, r); chk("R4 read shows complete", r, sts(0, 1, 1, 0));
        chk("R9 irq drops after read", DW'(irq), 32'h0);

        repeat (5) @(negedge bus_clk);
        summary();
    end
endmodule